// File: doc/BRIEF.md
# Interrupt Pending Latch and Message Dispatcher

This block watches a set of interrupt request lines and turns them into interrupt delivery messages, one at a time. Each pin has a 64-bit routing entry that is stored outside the block and presented on a flat input bus. The entry sets the pin's trigger mode (edge or level) and its mask, and it supplies the fields of the message: target, target addressing mode, delivery kind, vector and polarity. Requests are latched into a per-pin pending register. An edge pin sets its bit on a rising transition of its line. A level pin's bit follows its line. Request line 0 does not drive pin 0. It is steered onto pin 2, where it is ORed with line 2.

A scan is armed when any line rises or when the routing table reports a write. The scan captures every pending, unmasked pin, and those pins are then dispatched lowest-numbered first over a valid/ready output. An edge pin gives up its pending bit when its message is launched. A level pin keeps its bit, so it is delivered again on the next scan while its line stays high. A masked pin is passed over and stays pending. When an entry asks for the external delivery kind, the vector comes from a legacy interrupt controller through a request/acknowledge handshake, and the message becomes valid only after the acknowledge.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is low, and in the first cycle after it, `msg_valid_o` and `ext_req_o` are 0.
- R2: The message carries these entry fields: target from bits 63:56, addressing mode from bit 11, delivery kind from bits 10:8, vector from bits 7:0, polarity from bit 13 and trigger mode from bit 15 (1 = level, 0 = edge).
- R3: When several pins are eligible in one scan, their messages leave in ascending pin order, one per handshake.
- R4: A pin whose entry has bit 16 set (masked) produces no message but stays pending. A later entry write that clears the mask delivers it.
- R5: An edge pin yields exactly one message per rising transition of its line. Holding the line high or lowering it produces nothing further.
- R6: A level pin is pending exactly while its line is high. A pin whose line drops before it is dispatched produces no message, even when a later scan occurs.
- R7: Request line 0 sets pin 2, which uses pin 2's entry. Pin 0 never produces a message.
- R8: With delivery kind 7, `ext_req_o` rises and holds until `ext_ack_i`, `msg_valid_o` stays low meanwhile, and the message vector is `ext_vec_i` as sampled with the acknowledge.
- R9: An entry write (`rte_wr_i`) starts a new scan, so a level pin whose line is still high is delivered again.
- R10: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the valid signal and every message field stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line_i | input | NUM_PINS | Interrupt request lines |
| rte_flat_i | input | NUM_PINS*64 | Routing entries, pin k at bits k*64 +: 64 |
| rte_wr_i | input | 1 | Pulse: an entry was written, triggers a scan |
| ext_req_o | output | 1 | Vector request to the legacy controller |
| ext_ack_i | input | 1 | Legacy controller acknowledge |
| ext_vec_i | input | 8 | Vector returned with the acknowledge |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_dest_o | output | 8 | Message target |
| msg_dest_mode_o | output | 1 | Target addressing mode |
| msg_deliv_o | output | 3 | Delivery kind |
| msg_vec_o | output | 8 | Vector |
| msg_pol_o | output | 1 | Line polarity |
| msg_trig_o | output | 1 | Trigger mode |

## Verification
Single-pin pulses with random entry contents show that every field is routed correctly. They also confirm that only one message follows each rising edge. A simultaneous pulse on three pins, with ready held low, separates correct ascending order from any other order, and it exposes a message that changes while it waits. Level lines held high across entry writes, and dropped while masked, distinguish re-delivery per scan from latching and from continuous flooding. Pulses on line 0 and delivery-kind-7 entries check the steering onto pin 2 and the external vector path.

// File: rtl/irq_disp_pkg.sv
// Package: shared field positions, message type and state encoding for the
// interrupt dispatcher. Assumes the 64-bit routing entry layout below.
package irq_disp_pkg;

    localparam int RTE_W      = 64;
    localparam int VEC_W      = 8;
    localparam int DEST_W     = 8;
    localparam int DEST_LSB   = 56;
    localparam int DMODE_LSB  = 8;
    localparam int DESTM_BIT  = 11;
    localparam int POL_BIT    = 13;
    localparam int TRIG_BIT   = 15;
    localparam int MASK_BIT   = 16;

    localparam logic [2:0] DELIV_EXTERNAL = 3'd7;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_mode;
        logic [2:0]        deliv;
        logic [VEC_W-1:0]  vector;
        logic              pol;
        logic              trig;
    } irq_msg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } disp_state_e;

    // Extract the message fields from one routing entry.
    function automatic irq_msg_t decode_entry(input logic [RTE_W-1:0] e);
        irq_msg_t m;
        m.dest      = e[DEST_LSB +: DEST_W];
        m.dest_mode = e[DESTM_BIT];
        m.deliv     = e[DMODE_LSB +: 3];
        m.vector    = e[VEC_W-1:0];
        m.pol       = e[POL_BIT];
        m.trig      = e[TRIG_BIT];
        return m;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
// Module: per-pin pending register and scan set.
// Steers line LEGACY_SRC onto pin LEGACY_DST (the two must differ). Edge pins
// latch rising transitions and clear on launch. Level pins follow their line.
// A scan (any rising line or an entry write) captures every pending unmasked
// pin into the scan set. Launched pins leave the set.
module irq_pend_latch #(
    parameter int NUM_PINS   = 24,
    parameter int LEGACY_SRC = 0,
    parameter int LEGACY_DST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lines_i,
    input  logic [NUM_PINS-1:0] trig_lvl_i,
    input  logic [NUM_PINS-1:0] mask_i,
    input  logic                rescan_i,
    input  logic                launch_i,
    input  logic [NUM_PINS-1:0] launch_oh_i,
    output logic [NUM_PINS-1:0] elig_o
);

    logic [NUM_PINS-1:0] routed;
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] pend_q, pend_nx;
    logic [NUM_PINS-1:0] todo_q, todo_nx;
    logic [NUM_PINS-1:0] clr;
    logic                scan;

    // Line-to-pin steering: the legacy source feeds the destination pin only.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_route
        if (g == LEGACY_SRC) begin : g_src
            assign routed[g] = 1'b0;
        end else if (g == LEGACY_DST) begin : g_dst
            assign routed[g] = lines_i[g] | lines_i[LEGACY_SRC];
        end else begin : g_plain
            assign routed[g] = lines_i[g];
        end
    end

    assign rise = routed & ~prev_q;
    assign scan = (|rise) | rescan_i;

    // Next pending and scan-set values.
    always_comb begin
        clr = launch_i ? launch_oh_i : '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            pend_nx[i] = trig_lvl_i[i] ? routed[i]
                                       : ((pend_q[i] & ~clr[i]) | rise[i]);
        end
        todo_nx = ((todo_q & ~clr) | {NUM_PINS{scan}}) & pend_nx & ~mask_i;
    end

    // State registers for line history, pending bits and scan set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            todo_q <= '0;
        end else begin
            prev_q <= routed;
            pend_q <= pend_nx;
            todo_q <= todo_nx;
        end
    end

    assign elig_o = todo_q & pend_q & ~mask_i;

endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Purely combinational. The grant is one-hot or zero.
module irq_prio_pick #(
    parameter int N     = 24,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    logic found;

    // Scan upward and keep the first requester.
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                found    = 1'b1;
                gnt_o[i] = 1'b1;
                idx_o    = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_msg_stage.sv
// Module: output message register with external-vector fetch.
// Launches when idle and a pin is eligible. Delivery kind 7 waits for the
// legacy acknowledge and takes its vector. The message holds until ready.
module irq_msg_stage
    import irq_disp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  irq_msg_t         msg_i,
    output logic             launch_o,
    output logic             ext_req_o,
    input  logic             ext_ack_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    output logic             valid_o,
    input  logic             ready_i,
    output irq_msg_t         msg_o
);

    disp_state_e state_q;
    irq_msg_t    msg_q;

    assign launch_o = (state_q == ST_IDLE) && any_i;

    // Message state machine: idle, fetch the vector, present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msg_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any_i) begin
                        msg_q   <= msg_i;
                        state_q <= (msg_i.deliv == DELIV_EXTERNAL) ? ST_FETCH : ST_SEND;
                    end
                end
                ST_FETCH: begin
                    if (ext_ack_i) begin
                        msg_q.vector <= ext_vec_i;
                        state_q      <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (ready_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ext_req_o = (state_q == ST_FETCH);
    assign valid_o   = (state_q == ST_SEND);
    assign msg_o     = msg_q;

endmodule

// File: rtl/irq_dispatch.sv
// Module: top of the interrupt pending latch and dispatcher.
// Splits the flat routing-table bus into per-pin entries, latches requests,
// picks the lowest eligible pin and emits one message per valid/ready
// handshake. Table storage lives outside the block.
module irq_dispatch
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS   = 24,
    parameter int LEGACY_SRC = 0,
    parameter int LEGACY_DST = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       irq_line_i,
    input  logic [NUM_PINS*RTE_W-1:0] rte_flat_i,
    input  logic                      rte_wr_i,
    output logic                      ext_req_o,
    input  logic                      ext_ack_i,
    input  logic [VEC_W-1:0]          ext_vec_i,
    output logic                      msg_valid_o,
    input  logic                      msg_ready_i,
    output logic [DEST_W-1:0]         msg_dest_o,
    output logic                      msg_dest_mode_o,
    output logic [2:0]                msg_deliv_o,
    output logic [VEC_W-1:0]          msg_vec_o,
    output logic                      msg_pol_o,
    output logic                      msg_trig_o
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [RTE_W-1:0]    ent_arr [NUM_PINS];
    logic [NUM_PINS-1:0] trig_lvl;
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] elig;
    logic [NUM_PINS-1:0] gnt;
    logic [IDX_W-1:0]    pick_idx;
    logic                pick_any;
    logic                launch;
    irq_msg_t            pick_msg;
    irq_msg_t            out_msg;

    // Per-pin entry split and control-bit extraction.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        assign ent_arr[g]  = rte_flat_i[g*RTE_W +: RTE_W];
        assign trig_lvl[g] = ent_arr[g][TRIG_BIT];
        assign mask[g]     = ent_arr[g][MASK_BIT];
    end

    irq_pend_latch #(
        .NUM_PINS   (NUM_PINS),
        .LEGACY_SRC (LEGACY_SRC),
        .LEGACY_DST (LEGACY_DST)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_i     (irq_line_i),
        .trig_lvl_i  (trig_lvl),
        .mask_i      (mask),
        .rescan_i    (rte_wr_i),
        .launch_i    (launch),
        .launch_oh_i (gnt),
        .elig_o      (elig)
    );

    irq_prio_pick #(
        .N     (NUM_PINS),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i (elig),
        .gnt_o (gnt),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    assign pick_msg = decode_entry(ent_arr[pick_idx]);

    irq_msg_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (pick_any),
        .msg_i     (pick_msg),
        .launch_o  (launch),
        .ext_req_o (ext_req_o),
        .ext_ack_i (ext_ack_i),
        .ext_vec_i (ext_vec_i),
        .valid_o   (msg_valid_o),
        .ready_i   (msg_ready_i),
        .msg_o     (out_msg)
    );

    assign msg_dest_o      = out_msg.dest;
    assign msg_dest_mode_o = out_msg.dest_mode;
    assign msg_deliv_o     = out_msg.deliv;
    assign msg_vec_o       = out_msg.vector;
    assign msg_pol_o       = out_msg.pol;
    assign msg_trig_o      = out_msg.trig;

endmodule

// File: rtl/irq_dispatch_chk.sv
// Checker: port-level protocol properties of irq_dispatch, attached by bind.
module irq_dispatch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_req_o,
    input logic       ext_ack_i,
    input logic [7:0] ext_vec_i,
    input logic       msg_valid_o,
    input logic       msg_ready_i,
    input logic [7:0] msg_dest_o,
    input logic       msg_dest_mode_o,
    input logic [2:0] msg_deliv_o,
    input logic [7:0] msg_vec_o,
    input logic       msg_pol_o,
    input logic       msg_trig_o
);

    // R1: reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid_o && !ext_req_o));

    // R10: a waiting message does not change
    a_r10_hold_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o
            && $stable(msg_dest_o) && $stable(msg_dest_mode_o)
            && $stable(msg_deliv_o) && $stable(msg_vec_o)
            && $stable(msg_pol_o) && $stable(msg_trig_o)));

    // R8: the vector request holds until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && !ext_ack_i) |=> ext_req_o);

    // R8: no message while the vector is being fetched
    a_r8_no_valid_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_o |-> !msg_valid_o);

    // R8: the acknowledged vector becomes the message vector
    a_r8_ext_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req_o && ext_ack_i) |=> (msg_valid_o && msg_vec_o == $past(ext_vec_i)));

    // R8: an external-kind message is always preceded by a fetch
    a_r8_ext_fetched: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid_o) && msg_deliv_o == 3'd7) |-> $past(ext_req_o));

endmodule

bind irq_dispatch irq_dispatch_chk u_irq_dispatch_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ext_req_o       (ext_req_o),
    .ext_ack_i       (ext_ack_i),
    .ext_vec_i       (ext_vec_i),
    .msg_valid_o     (msg_valid_o),
    .msg_ready_i     (msg_ready_i),
    .msg_dest_o      (msg_dest_o),
    .msg_dest_mode_o (msg_dest_mode_o),
    .msg_deliv_o     (msg_deliv_o),
    .msg_vec_o       (msg_vec_o),
    .msg_pol_o       (msg_pol_o),
    .msg_trig_o      (msg_trig_o)
);

// File: tb/test_irq_dispatch.sv
// Bench for irq_dispatch: directed corner cases plus seeded random pulses.
module test_irq_dispatch;

    localparam int NP = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     irq_in = '0;
    logic [63:0]       ent [NP];
    logic [NP*64-1:0]  rte_flat;
    logic              rte_wr = 1'b0;
    logic              ext_ack = 1'b0;
    logic [7:0]        ext_vec = '0;
    logic              ready = 1'b0;
    logic              ext_req, valid, dmode_o, pol_o, trig_o;
    logic [7:0]        dest_o, vec_o;
    logic [2:0]        deliv_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) rte_flat[i*64 +: 64] = ent[i];
    end

    irq_dispatch i_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .irq_line_i(irq_in), .rte_flat_i(rte_flat),
        .rte_wr_i(rte_wr), .ext_req_o(ext_req), .ext_ack_i(ext_ack),
        .ext_vec_i(ext_vec), .msg_valid_o(valid), .msg_ready_i(ready),
        .msg_dest_o(dest_o), .msg_dest_mode_o(dmode_o), .msg_deliv_o(deliv_o),
        .msg_vec_o(vec_o), .msg_pol_o(pol_o), .msg_trig_o(trig_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [7:0] dst, input logic dm,
                                       input logic [2:0] kind, input logic [7:0] v,
                                       input logic pol, input logic lvl, input logic msk);
        return {dst, 39'd0, msk, lvl, 1'b0, pol, 1'b0, dm, kind, v};
    endfunction

    function automatic logic [21:0] exp_fields(input logic [63:0] e, input logic [7:0] xv);
        return {e[63:56], e[11], e[10:8], (e[10:8] == 3'd7) ? xv : e[7:0], e[13], e[15]};
    endfunction

    function automatic logic [21:0] dut_fields();
        return {dest_o, dmode_o, deliv_o, vec_o, pol_o, trig_o};
    endfunction

    task automatic write_entry(input int p, input logic [63:0] v);
        @(negedge clk);
        ent[p] = v;
        rte_wr = 1'b1;
        @(negedge clk);
        rte_wr = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in[line] = 1'b0;
    endtask

    // Wait for the message of pin p, compare it, check it holds, then accept it.
    task automatic expect_msg(input string req, input int p, input logic [7:0] xv);
        logic [63:0] e;
        logic [21:0] held;
        int waited;
        e = ent[p];
        waited = 0;
        if (e[10:8] == 3'd7) begin
            while (!ext_req && waited < 20) begin
                @(negedge clk);
                waited++;
            end
            check({req, " R8 request"}, {31'd0, ext_req}, 32'd1);
            check({req, " R8 no valid during fetch"}, {31'd0, valid}, 32'd0);
            ext_vec = xv;
            ext_ack = 1'b1;
            @(negedge clk);
            ext_ack = 1'b0;
            waited = 0;
        end
        while (!valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check({req, " valid"}, {31'd0, valid}, 32'd1);
        check({req, " fields"}, {10'd0, dut_fields()}, {10'd0, exp_fields(e, xv)});
        held = dut_fields();
        @(negedge clk);
        check({req, " R10 hold"}, {9'd0, valid, dut_fields()}, {9'd0, 1'b1, held});
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    task automatic expect_none(input string req, input int cyc);
        logic seen;
        seen = 1'b0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            seen = seen | valid | ext_req;
        end
        check(req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] e;
        for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 1'b0, 3'd0, 8'(i), 1'b0, 1'b0, 1'b1);
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, valid}, 32'd0);
        check("R1 request in reset", {31'd0, ext_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, valid, ext_req}, 32'd0);

        // R2 and R5: edge pin, held high, then released, then pulsed again
        write_entry(5, mk(8'hA5, 1'b1, 3'd1, 8'h35, 1'b1, 1'b0, 1'b0));
        expect_none("R5 no message without request", 6);
        @(negedge clk);
        irq_in[5] = 1'b1;
        expect_msg("R2 edge pin 5", 5, 8'h00);
        expect_none("R5 held line gives one message", 10);
        @(negedge clk);
        irq_in[5] = 1'b0;
        expect_none("R5 falling edge ignored", 10);
        pulse(5);
        expect_msg("R5 second rising edge", 5, 8'h00);

        // R7: line 0 lands on pin 2, pin 0 stays silent
        write_entry(0, mk(8'h10, 1'b0, 3'd0, 8'h10, 1'b0, 1'b0, 1'b0));
        write_entry(2, mk(8'h22, 1'b0, 3'd0, 8'h22, 1'b0, 1'b0, 1'b0));
        pulse(0);
        expect_msg("R7 line 0 to pin 2", 2, 8'h00);
        expect_none("R7 pin 0 never delivers", 10);

        // R3 and R10: three pins at once, ascending order
        write_entry(9, mk(8'h09, 1'b0, 3'd0, 8'h99, 1'b0, 1'b0, 1'b0));
        write_entry(3, mk(8'h03, 1'b1, 3'd4, 8'h33, 1'b1, 1'b0, 1'b0));
        write_entry(7, mk(8'h07, 1'b0, 3'd2, 8'h77, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        irq_in[3] = 1'b1; irq_in[7] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        irq_in[3] = 1'b0; irq_in[7] = 1'b0; irq_in[9] = 1'b0;
        expect_msg("R3 first pin 3", 3, 8'h00);
        expect_msg("R3 second pin 7", 7, 8'h00);
        expect_msg("R3 third pin 9", 9, 8'h00);
        expect_none("R3 nothing after order", 6);

        // R4: masked pending pin delivered after unmask
        pulse(11);
        expect_none("R4 masked pin silent", 10);
        write_entry(11, mk(8'h0B, 1'b0, 3'd0, 8'hBB, 1'b0, 1'b0, 1'b0));
        expect_msg("R4 unmask delivers pending", 11, 8'h00);
        expect_none("R4 only once", 6);

        // R6 and R9: level pin
        write_entry(12, mk(8'h0C, 1'b1, 3'd0, 8'hCC, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        irq_in[12] = 1'b1;
        expect_msg("R6 level pin asserted", 12, 8'h00);
        expect_none("R6 steady level no flood", 10);
        write_entry(12, ent[12]);
        expect_msg("R9 rescan redelivers level", 12, 8'h00);
        @(negedge clk);
        irq_in[12] = 1'b0;
        write_entry(12, ent[12]);
        expect_none("R6 dropped level not delivered", 10);

        // R6: level pin raised and dropped while masked
        write_entry(13, mk(8'h0D, 1'b0, 3'd0, 8'hDD, 1'b0, 1'b1, 1'b1));
        pulse(13);
        write_entry(13, mk(8'h0D, 1'b0, 3'd0, 8'hDD, 1'b0, 1'b1, 1'b0));
        expect_none("R6 masked level dropped", 10);

        // R8: external vector fetch
        write_entry(14, mk(8'h0E, 1'b0, 3'd7, 8'hEE, 1'b0, 1'b0, 1'b0));
        pulse(14);
        expect_msg("R8 external vector", 14, 8'h5A);

        // Random pulses with random entries (R2, R7, R8)
        for (int k = 0; k < 40; k++) begin
            int p;
            int line;
            logic [7:0] xv;
            p = 1 + int'($urandom_range(22, 0));
            line = (p == 2 && $urandom_range(1, 0) == 1) ? 0 : p;
            xv = 8'($urandom);
            e = mk(8'($urandom), 1'($urandom), 3'($urandom_range(7, 0)),
                   8'($urandom), 1'($urandom), 1'b0, 1'b0);
            write_entry(p, e);
            pulse(line);
            expect_msg("R2 random entry", p, xv);
            write_entry(p, e | (64'd1 << 16));
        end
        expect_none("R5 quiet at end", 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule